// File: doc/BRIEF.md
# NOR Flash Sector Access Engine

This block turns host requests on 512-byte logical sectors into serial NOR flash command sequences that use 4-byte addresses. A request names an operation (read, program or erase), a start sector and a sector count. The engine builds each flash transaction itself: it drives chip select, sends the command byte and the address, and moves data bytes between the flash and two byte-wide ready/valid ports.

The engine talks to a byte-transfer SPI master. It offers one byte at a time and receives one byte back per transfer. The serial shift logic lives in that master. Programs go one sector per transaction. Erases walk the requested range in fixed 256 KiB steps. Every program or erase transaction is preceded by its own write-enable window and followed by status polling. The whole series closes with a write-disable window.

The host sees `busy` while a request runs and a one-cycle `done` when it ends. The engine does not read-modify-write partial erase blocks, so callers align erase ranges themselves.

Top module: `nor_sector_engine`

## Requirements
- R1: After reset, busy, done, spi_tx_valid and rd_valid are 0 and spi_cs_n is 1.
- R2: The flash byte address is start sector × 512. It is sent as 4 bytes, most significant byte first, directly after the command byte. req_op encodes 0 = read, 1 = program, 2 = erase, 3 = no operation.
- R3: A read is one chip-select window holding 0x13, the address, then count × 512 bytes each transmitted as 0xFF. The received data bytes appear on rd_data in order. A count of 0 sends only the command and address.
- R4: A program sends each sector in its own window: 0x12, the sector's address, then 512 bytes taken in order from the write port. Chip select rises right after the last data byte.
- R5: An erase sends windows of 0xDC plus an address. The first address is the start address and each next one is 256 KiB higher. Windows continue while the address is below (start sector + count) × 512.
- R6: Every program or erase window is preceded by a window holding only 0x06.
- R7: After every program or erase window, the engine polls in windows of 0x05 then 0xFF. It repeats them until the byte received during the 0xFF has bit 0 clear.
- R8: After a whole program or erase series, a window holding only 0x04 is sent. A program or erase with count 0 sends only this window.
- R9: Write data is taken only when wr_valid and wr_ready are both high. wr_ready is low whenever spi_tx_ready is low. A read byte stays on rd_data with rd_valid high until rd_ready accepts it, so no byte is lost.
- R10: busy is high from the cycle after a request is accepted until the request ends. done is then high for exactly one cycle, with busy already low.
- R11: Requests presented while busy, and requests with op 3, are ignored and cause no flash traffic.
- R12: At most one byte transfer is outstanding at a time. spi_tx_valid is asserted only while spi_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 none |
| req_sector | input | SECT_W | Start sector (512-byte units) |
| req_count | input | CNT_W | Number of sectors |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data available |
| wr_ready | output | 1 | Program byte taken this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte held for the consumer |
| rd_ready | input | 1 | Consumer accepts the read byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_tx_valid | output | 1 | Start a byte transfer |
| spi_tx_ready | input | 1 | SPI master can take a byte |
| spi_rx_data | input | 8 | Byte shifted in |
| spi_rx_valid | input | 1 | Transfer finished, rx byte valid |

## Verification
Assertions check the cycle-level rules on every cycle:
- transfers only while chip select is low;
- no second transfer while one is outstanding;
- no read byte overwritten or changed while stalled;
- write-port readiness only while busy;
- the one-cycle done pulse that follows busy.

The command streams themselves can only be shown by the bench's scenarios. These cover opcode and address order, window boundaries, the 256 KiB erase stepping over unaligned ranges, repeated polling until the flash reports idle, zero-count requests, and the dropping of requests made while busy. The bench checks them by comparing every transmitted byte and every chip-select release against an expected stream, under random stalls on both data ports and on the SPI master.

// File: rtl/nse_pkg.sv
// Shared types and command bytes for the NOR sector access engine.
// Assumes a flash part that takes 4-byte-address commands.
package nse_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } nse_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WREN,
        S_HDR,
        S_RDATA,
        S_WDATA,
        S_POLL,
        S_WRDI,
        S_GAP
    } nse_state_e;

    localparam logic [7:0] CMD_READ4  = 8'h13;
    localparam logic [7:0] CMD_PROG4  = 8'h12;
    localparam logic [7:0] CMD_ERASE4 = 8'hDC;
    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_WRDI   = 8'h04;
    localparam logic [7:0] CMD_RDSR   = 8'h05;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;

    // Command byte that opens the data transaction of an operation
    function automatic logic [7:0] op_cmd(nse_op_e op);
        case (op)
            OP_PROG:  return CMD_PROG4;
            OP_ERASE: return CMD_ERASE4;
            default:  return CMD_READ4;
        endcase
    endfunction

    // States in which chip select is held low
    function automatic logic cs_low(nse_state_e s);
        return (s == S_WREN) || (s == S_HDR) || (s == S_RDATA) ||
               (s == S_WDATA) || (s == S_POLL) || (s == S_WRDI);
    endfunction

endpackage

// File: rtl/nse_addr_seq.sv
// Address sequencer: holds the current flash byte address and the end of
// the requested range, steps by a sector or by an erase block, and serves
// header address bytes most significant first.
// Assumes SECT_W + log2(SECTOR_BYTES) <= ADDR_W.
module nse_addr_seq #(
    parameter int ADDR_W       = 32,
    parameter int SECT_W       = 23,
    parameter int CNT_W        = 16,
    parameter int SECTOR_BYTES = 512,
    parameter int ERASE_BYTES  = 262144,
    localparam int ADDR_BYTES  = ADDR_W / 8,
    localparam int SEL_W       = $clog2(ADDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SECT_W-1:0] sector,
    input  logic [CNT_W-1:0]  count,
    input  logic              step_sector,
    input  logic              step_erase,
    input  logic [SEL_W-1:0]  hdr_sel,
    output logic [7:0]        addr_byte,
    output logic              more_any,
    output logic              more_sector,
    output logic              more_erase
);
    localparam int SHIFT = $clog2(SECTOR_BYTES);
    localparam int EW    = ADDR_W + 1;

    logic [EW-1:0] cur_q, end_q;

    // Load the range on request, then advance by the selected unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            end_q <= '0;
        end else if (load) begin
            cur_q <= EW'(sector) << SHIFT;
            end_q <= (EW'(sector) + EW'(count)) << SHIFT;
        end else if (step_sector) begin
            cur_q <= cur_q + EW'(SECTOR_BYTES);
        end else if (step_erase) begin
            cur_q <= cur_q + EW'(ERASE_BYTES);
        end
    end

    // Range tests and header byte selection
    always_comb begin
        more_any    = cur_q < end_q;
        more_sector = (cur_q + EW'(SECTOR_BYTES)) < end_q;
        more_erase  = (cur_q + EW'(ERASE_BYTES)) < end_q;
        addr_byte   = 8'(cur_q[ADDR_W-1:0] >> (8 * (ADDR_BYTES - 1 - int'(hdr_sel))));
    end

    // R5: the address only moves upward between loads
    // R5
    addr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cur_q >= $past(cur_q)));
endmodule

// File: rtl/nse_xfer_track.sv
// Byte-transfer tracker: offers a byte to the SPI master only when no
// transfer is outstanding, and marks the transfer finished on rx_valid.
// Assumes the master returns exactly one rx_valid per accepted byte.
module nse_xfer_track (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic tx_ready,
    input  logic rx_valid,
    output logic tx_valid,
    output logic pending
);
    logic pend_q;

    assign tx_valid = want && !pend_q;
    assign pending  = pend_q;

    // Set on an accepted byte, clear on its completion
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (tx_valid && tx_ready) pend_q <= 1'b1;
        else if (rx_valid)           pend_q <= 1'b0;
    end

    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> pend_q);
    // R12
    hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !rx_valid) |=> pend_q);
endmodule

// File: rtl/nse_rd_buf.sv
// Read output register: holds one received byte for the consumer until it
// is accepted. Assumes the controller loads it only while it is empty.
module nse_rd_buf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       rd_ready,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    logic [7:0] data_q;
    logic       valid_q;

    assign rd_data  = data_q;
    assign rd_valid = valid_q;

    // Capture a byte; release it when the consumer takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            data_q  <= din;
            valid_q <= 1'b1;
        end else if (rd_ready) begin
            valid_q <= 1'b0;
        end
    end

    // R9
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid_q);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !rd_ready) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/nor_sector_engine.sv
// NOR sector access engine: maps 512-byte sector read/program/erase
// requests to 4-byte-address flash command windows over a byte SPI master.
// Assumes sectors align to program pages and erase ranges to erase blocks.
module nor_sector_engine
    import nse_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int SECT_W       = 23,
    parameter int CNT_W        = 16,
    parameter int SECTOR_BYTES = 512,
    parameter int ERASE_BYTES  = 262144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [SECT_W-1:0] req_sector,
    input  logic [CNT_W-1:0]  req_count,
    output logic              busy,
    output logic              done,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              spi_cs_n,
    output logic [7:0]        spi_tx_data,
    output logic              spi_tx_valid,
    input  logic              spi_tx_ready,
    input  logic [7:0]        spi_rx_data,
    input  logic              spi_rx_valid
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int SEL_W      = $clog2(ADDR_BYTES);
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);
    localparam int BCNT_W     = $clog2(SECTOR_BYTES);

    nse_state_e        state_q, state_d, ret_q, ret_d;
    nse_op_e           op_q, op_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [BCNT_W-1:0] bcnt_q, bcnt_d;
    logic              cs_n_q, done_q;

    logic              load, step_s, step_e, rd_load, want, pend;
    logic              more_any, more_sector, more_erase;
    logic [7:0]        addr_byte, tx_byte;
    logic [SEL_W-1:0]  hdr_sel;

    assign hdr_sel     = SEL_W'(idx_q - IDX_W'(1));
    assign spi_tx_data = tx_byte;
    assign spi_cs_n    = cs_n_q;
    assign busy        = (state_q != S_IDLE);
    assign done        = done_q;

    nse_addr_seq #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .CNT_W(CNT_W),
        .SECTOR_BYTES(SECTOR_BYTES), .ERASE_BYTES(ERASE_BYTES)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load),
        .sector(req_sector), .count(req_count),
        .step_sector(step_s), .step_erase(step_e),
        .hdr_sel(hdr_sel), .addr_byte(addr_byte),
        .more_any(more_any), .more_sector(more_sector), .more_erase(more_erase)
    );

    nse_xfer_track u_xfer (
        .clk(clk), .rst_n(rst_n), .want(want),
        .tx_ready(spi_tx_ready), .rx_valid(spi_rx_valid),
        .tx_valid(spi_tx_valid), .pending(pend)
    );

    nse_rd_buf u_rbuf (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .din(spi_rx_data),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Sequencing: choose the byte to send and the next state
    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        op_d     = op_q;
        idx_d    = idx_q;
        bcnt_d   = bcnt_q;
        load     = 1'b0;
        step_s   = 1'b0;
        step_e   = 1'b0;
        rd_load  = 1'b0;
        want     = 1'b0;
        tx_byte  = FILL_BYTE;
        wr_ready = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (req_valid && nse_op_e'(req_op) != OP_NONE) begin
                    load   = 1'b1;
                    op_d   = nse_op_e'(req_op);
                    idx_d  = '0;
                    bcnt_d = '0;
                    if (nse_op_e'(req_op) == OP_READ) state_d = S_HDR;
                    else if (req_count != '0)         state_d = S_WREN;
                    else                              state_d = S_WRDI;
                end
            end
            S_WREN: begin
                want    = 1'b1;
                tx_byte = CMD_WREN;
                if (spi_rx_valid) begin
                    state_d = S_GAP;
                    ret_d   = S_HDR;
                    idx_d   = '0;
                end
            end
            S_HDR: begin
                want    = 1'b1;
                tx_byte = (idx_q == '0) ? op_cmd(op_q) : addr_byte;
                if (spi_rx_valid) begin
                    if (idx_q == IDX_W'(ADDR_BYTES)) begin
                        idx_d  = '0;
                        bcnt_d = '0;
                        case (op_q)
                            OP_READ:  state_d = more_any ? S_RDATA : S_IDLE;
                            OP_PROG:  state_d = S_WDATA;
                            default: begin
                                state_d = S_GAP;
                                ret_d   = S_POLL;
                            end
                        endcase
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            S_RDATA: begin
                want    = !rd_valid;
                tx_byte = FILL_BYTE;
                if (spi_rx_valid) begin
                    rd_load = 1'b1;
                    bcnt_d  = bcnt_q + BCNT_W'(1);
                    if (&bcnt_q) begin
                        step_s = 1'b1;
                        if (!more_sector) state_d = S_IDLE;
                    end
                end
            end
            S_WDATA: begin
                want     = wr_valid;
                tx_byte  = wr_data;
                wr_ready = !pend && spi_tx_ready;
                if (spi_rx_valid) begin
                    bcnt_d = bcnt_q + BCNT_W'(1);
                    if (&bcnt_q) begin
                        state_d = S_GAP;
                        ret_d   = S_POLL;
                        idx_d   = '0;
                    end
                end
            end
            S_POLL: begin
                want    = 1'b1;
                tx_byte = (idx_q == '0) ? CMD_RDSR : FILL_BYTE;
                if (spi_rx_valid) begin
                    if (idx_q == '0) begin
                        idx_d = IDX_W'(1);
                    end else begin
                        idx_d   = '0;
                        state_d = S_GAP;
                        if (spi_rx_data[0]) begin
                            ret_d = S_POLL;
                        end else if (op_q == OP_PROG) begin
                            step_s = 1'b1;
                            ret_d  = more_sector ? S_WREN : S_WRDI;
                        end else begin
                            step_e = 1'b1;
                            ret_d  = more_erase ? S_WREN : S_WRDI;
                        end
                    end
                end
            end
            S_WRDI: begin
                want    = 1'b1;
                tx_byte = CMD_WRDI;
                if (spi_rx_valid) state_d = S_IDLE;
            end
            default: begin
                state_d = ret_q;
            end
        endcase
    end

    // State, counters, chip select and the end-of-request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ret_q   <= S_IDLE;
            op_q    <= OP_READ;
            idx_q   <= '0;
            bcnt_q  <= '0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            op_q    <= op_d;
            idx_q   <= idx_d;
            bcnt_q  <= bcnt_d;
            cs_n_q  <= !cs_low(state_d);
            done_q  <= (state_q != S_IDLE) && (state_d == S_IDLE);
        end
    end

    // R12
    tx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_valid |-> !spi_cs_n);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R9
    wr_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (busy && spi_tx_ready));
endmodule

// File: tb/nor_sector_engine_test.sv
// Scoreboard bench: driver tasks queue the expected byte/chip-select stream
// and read data; one monitor process compares them as the design runs.
module nor_sector_engine_test;
    localparam int SECT_W = 23;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [SECT_W-1:0] req_sector = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic busy, done, wr_ready, rd_valid, spi_cs_n, spi_tx_valid;
    logic [7:0] rd_data, spi_tx_data;
    logic [7:0] wr_data = '0;
    logic wr_valid = 1'b0, rd_ready = 1'b0;
    logic spi_tx_ready = 1'b0, spi_rx_valid = 1'b0;
    logic [7:0] spi_rx_data = '0;

    always #2 clk = ~clk;

    nor_sector_engine uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sector(req_sector), .req_count(req_count), .busy(busy), .done(done),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .spi_cs_n(spi_cs_n), .spi_tx_data(spi_tx_data), .spi_tx_valid(spi_tx_valid),
        .spi_tx_ready(spi_tx_ready), .spi_rx_data(spi_rx_data), .spi_rx_valid(spi_rx_valid)
    );

    int checks = 0, fails = 0;
    logic [8:0] expq[$];
    int         tagq[$];
    logic [7:0] rdq[$];
    logic [7:0] wrq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fmem(input logic [31:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h3C;
    endfunction

    task automatic push(input logic [8:0] item, input int tag);
        expq.push_back(item);
        tagq.push_back(tag);
    endtask

    task automatic push_addr(input logic [31:0] a, input int tag);
        for (int k = 3; k >= 0; k--) push({1'b0, a[8*k +: 8]}, tag);
    endtask

    // R7: the model reports busy twice, so three status windows per operation
    task automatic push_polls();
        for (int p = 0; p < 3; p++) begin
            push(9'h005, 7); push(9'h0FF, 7); push(9'h100, 7);
        end
    endtask

    // Flash model and port agents: drive at negedge, sample 1 ns later
    logic [15:0] lf = 16'hACE1;
    int lat = 0, win_idx = 0, wip_left = 0;
    logic [7:0] win_op = '0, resp = '0;
    logic [31:0] faddr = '0;
    logic prev_cs = 1'b1;
    logic stall_seen = 1'b0;
    logic [7:0] stall_data = '0;

    always @(negedge clk) begin
        lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        spi_rx_valid <= 1'b0;
        if (lat > 0) begin
            lat = lat - 1;
            if (lat == 0) begin
                spi_rx_valid <= 1'b1;
                spi_rx_data  <= resp;
            end
        end
        spi_tx_ready <= lf[0] | lf[3];
        rd_ready     <= lf[5] | lf[7];
        wr_valid     <= (wrq.size() > 0) && (lf[9] | lf[2]);
        wr_data      <= (wrq.size() > 0) ? wrq[0] : 8'h00;
        #1;
        if (rst_n) begin
            if (spi_tx_valid && spi_tx_ready) begin
                // flash model response
                if (win_idx == 0) begin
                    win_op = spi_tx_data; resp = 8'hFF;
                end else if (win_op == 8'h05) begin
                    resp = {7'b0, wip_left != 0};
                    if (wip_left > 0) wip_left--;
                end else if (win_op == 8'h13) begin
                    if (win_idx <= 4) begin
                        faddr = {faddr[23:0], spi_tx_data}; resp = 8'hFF;
                    end else begin
                        resp = fmem(faddr + 32'(win_idx - 5));
                    end
                end else begin
                    resp = 8'hFF;
                end
                win_idx++;
                lat = 2;
                // R12: every transmitted byte is compared with the stream
                if (expq.size() == 0) begin
                    check(0, "R12", "unexpected tx byte", spi_tx_data, 0);
                end else begin
                    int t;
                    logic [8:0] e;
                    e = expq.pop_front(); t = tagq.pop_front();
                    check({1'b0, spi_tx_data} == e, $sformatf("R%0d", t), "tx byte",
                          spi_tx_data, e);
                end
            end
            if (spi_cs_n && !prev_cs) begin
                if (win_op == 8'h12 || win_op == 8'hDC) wip_left = 2;
                win_idx = 0;
                if (expq.size() == 0) begin
                    check(0, "R12", "unexpected cs release", 1, 0);
                end else begin
                    int t;
                    logic [8:0] e;
                    e = expq.pop_front(); t = tagq.pop_front();
                    check(e == 9'h100, $sformatf("R%0d", t), "cs release here", 9'h100, e);
                end
            end
            prev_cs = spi_cs_n;
            // R9: program data advances only on a handshake
            if (wr_valid && wr_ready) void'(wrq.pop_front());
            if (wr_ready && !spi_tx_ready)
                check(0, "R9", "wr_ready without master ready", 1, 0);
            // R9 / R3: read bytes in order, held while stalled
            if (stall_seen)
                check(rd_valid && rd_data == stall_data, "R9", "stalled byte held",
                      rd_data, stall_data);
            stall_seen = rd_valid && !rd_ready;
            stall_data = rd_data;
            if (rd_valid && rd_ready) begin
                if (rdq.size() == 0) check(0, "R3", "unexpected read byte", rd_data, 0);
                else begin
                    logic [7:0] x;
                    x = rdq.pop_front();
                    check(rd_data == x, "R3", "read data", rd_data, x);
                end
            end
        end
    end

    // Drive one request and wait for its single done pulse
    task automatic run_req(input logic [1:0] op, input logic [SECT_W-1:0] sec,
                           input logic [CNT_W-1:0] cnt, input bit inject);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sector = sec; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(busy == 1'b1, "R10", "busy after accept", busy, 1);
        n = 0;
        while (!done && n < 60000) begin
            @(negedge clk);
            // R11: a request while busy must cause no traffic
            if (inject && n == 20) begin
                req_valid = 1'b1; req_op = 2'd0; req_sector = 7; req_count = 1;
            end else begin
                req_valid = 1'b0;
            end
            #1;
            n++;
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R10", "done seen", done, 1);
        check(busy == 1'b0, "R10", "busy low with done", busy, 0);
        @(negedge clk); #1;
        check(done == 1'b0, "R10", "done one cycle", done, 0);
        repeat (8) @(negedge clk);
        #1;
        check(expq.size() == 0, "R11", "expected stream drained", expq.size(), 0);
        check(rdq.size() == 0, "R3", "read data drained", rdq.size(), 0);
        check(wrq.size() == 0, "R4", "write data consumed", wrq.size(), 0);
        check(busy == 1'b0, "R11", "idle after request", busy, 0);
    endtask

    // R2 R3: read stream expectations
    task automatic do_read(input logic [SECT_W-1:0] sec, input int cnt);
        logic [31:0] a;
        a = 32'(sec) << 9;
        push(9'h013, 3);
        push_addr(a, 2);
        for (int i = 0; i < cnt * 512; i++) begin
            push(9'h0FF, 3);
            rdq.push_back(fmem(a + 32'(i)));
        end
        push(9'h100, 3);
        run_req(2'd0, sec, CNT_W'(cnt), 1'b0);
    endtask

    // R4 R6 R7 R8: program stream expectations
    task automatic do_prog(input logic [SECT_W-1:0] sec, input int cnt, input bit inject);
        for (int s = 0; s < cnt; s++) begin
            push(9'h006, 6); push(9'h100, 6);
            push(9'h012, 4);
            push_addr((32'(sec) + 32'(s)) << 9, 2);
            for (int i = 0; i < 512; i++) begin
                logic [7:0] d;
                d = 8'(s * 29 + i) ^ 8'hA5;
                push({1'b0, d}, 4);
                wrq.push_back(d);
            end
            push(9'h100, 4);
            push_polls();
        end
        push(9'h004, 8); push(9'h100, 8);
        run_req(2'd1, sec, CNT_W'(cnt), inject);
    endtask

    // R5 R6 R7 R8: erase stream expectations in 256 KiB steps
    task automatic do_erase(input logic [SECT_W-1:0] sec, input int cnt);
        longint a, e;
        a = longint'(sec) * 512;
        e = (longint'(sec) + cnt) * 512;
        while (a < e) begin
            push(9'h006, 6); push(9'h100, 6);
            push(9'h0DC, 5);
            push_addr(32'(a), 5);
            push(9'h100, 5);
            push_polls();
            a += 262144;
        end
        push(9'h004, 8); push(9'h100, 8);
        run_req(2'd2, sec, CNT_W'(cnt), 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(done == 0, "R1", "done in reset", done, 0);
        check(spi_cs_n == 1, "R1", "cs_n in reset", spi_cs_n, 1);
        check(spi_tx_valid == 0, "R1", "tx_valid in reset", spi_tx_valid, 0);
        check(rd_valid == 0, "R1", "rd_valid in reset", rd_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        do_read(23'd5, 2);                  // R3 multi-sector stream
        do_read(23'h7FFFFF, 1);             // R2 top address bytes 0xFFFFFE00
        do_read(23'd9, 0);                  // R3 header only
        do_prog(23'h1234, 2, 1'b1);         // R4 R6 R7 R8 R11
        do_erase(23'd100, 600);             // R5 unaligned range, two steps
        do_erase(23'd0, 512);               // R5 exactly one block
        do_prog(23'd3, 0, 1'b0);            // R8 zero count
        // R11: op 3 is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_count = 4;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) begin
            @(negedge clk); #1;
            check(busy == 0 && spi_cs_n == 1, "R11", "op 3 ignored", busy, 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule